// File: doc/BRIEF.md
# Byte-Wide Chained Configuration Loader

The loader takes a configuration stream one byte per rising edge of an externally driven clock and writes the payload into a fixed-size configuration store through a simple write port. A device's stream opens with a fixed-length header whose first byte is a preamble constant. Frames follow, each made of a start marker, a fixed number of payload bytes and a stop marker. Only the payload reaches the store. There is no length field. A device's share of the stream ends when its store is full.

Several loaders can share one clock and one byte bus. Each one hands the bus on through its status output. The status output stays low while the device is idle or loading and goes high once its store is full. That output drives the chip-select of the next device, so the next device picks up the following header on the very next edge. Every device pulls a shared open-drain done line low until its own store is full. Each device reports itself active only after the whole line has been released, so the chain starts together. Markers that do not match raise a sticky error and freeze the device.

Top module: `cfg_loader`

## Requirements
- R1: During and after reset, `statusOut` is 0, `doneLow` is 1, `errFlag` is 0, `memWe` is 0 and `devActive` is 0.
- R2: The first rising edge after reset is released is a wake-up edge and its byte is ignored. Bytes are sampled from the second rising edge on, one whole byte per edge.
- R3: A header is `HDR_BYTES` bytes long. Its first byte must equal `PREAMBLE`, and any other byte seen while waiting is discarded. The remaining header bytes are accepted with any value.
- R4: After the header, each frame is a byte equal to `FRAME_START`, then `PAYLOAD_BYTES` payload bytes, then a byte equal to `FRAME_STOP`. Payload bytes are written to addresses 0, 1, 2, … with no gap. A write appears on `memWe`/`memAddr`/`memData` in the cycle after the edge that sampled the byte.
- R5: A byte is taken only when `csIn` is 1 at the sampling edge. Any other byte leaves the state, the address and the write port unchanged.
- R6: `statusOut` rises on the edge that takes the stop marker of the frame that fills the store (`FRAMES*PAYLOAD_BYTES` payload bytes). After that it stays high and no further byte causes a write.
- R7: If a start or stop marker does not match, `errFlag` rises on that edge and stays high until reset. From then on the device makes no write, `statusOut` stays 0 and `doneLow` stays 1.
- R8: `doneLow` is 1 until the store is full and 0 afterwards. `devActive` is a registered copy of the wired `doneWire` input, so it rises one edge after the last device in the chain releases its done line.
- R9: When a device's `statusOut` drives the next device's `csIn`, the next device takes the byte that follows the filling stop marker as its own first header byte. The filling stop marker itself is never taken by the next device, even when it equals `PREAMBLE`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Externally driven configuration clock |
| rst | input | 1 | Synchronous reset, active high |
| dataIn | input | 8 | Shared configuration byte bus |
| csIn | input | 1 | Chip-select; tied high on the lead device |
| statusOut | output | 1 | High once the store is full; feeds the next device's chip-select |
| doneLow | output | 1 | 1 = pulling the shared open-drain done line low |
| doneWire | input | 1 | Resolved level of the shared done line |
| devActive | output | 1 | Registered: the whole chain has released done |
| errFlag | output | 1 | Sticky marker-mismatch error |
| memWe | output | 1 | Store write strobe |
| memAddr | output | ADDR_W | Store write address |
| memData | output | 8 | Store write data |

## Verification
One edge can both fill one device and hand the bus on. The stop marker that fills the lead device is sampled at the same edge at which that device's status turns its successor's chip-select on. The bench provokes this with a stop marker equal to the preamble and sends the successor's header straight after it, with no idle cycle. It judges the result by the second store holding exactly its own payload with no error, and the first store holding exactly its own payload. A second collision is also checked: the successor's final stop marker and the release of the shared done line. `devActive` must still be low just after that edge and high one edge later.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

  typedef enum logic [2:0] {
    S_WAKE,
    S_HUNT,
    S_HDR,
    S_FSTART,
    S_PAY,
    S_FSTOP,
    S_FULL,
    S_FAULT
  } ldState_e;

  typedef struct packed {
    logic cntClr;
    logic cntInc;
    logic memWr;
    logic errSet;
  } ldStrobe_t;

endpackage

// File: rtl/cfg_loader_dp.sv
module cfg_loader_dp
  import cfg_loader_pkg::*;
#(
  parameter int HDR_BYTES     = 3,
  parameter int PAYLOAD_BYTES = 4,
  parameter int FRAMES        = 4,
  parameter logic [7:0] PREAMBLE    = 8'hA5,
  parameter logic [7:0] FRAME_START = 8'hC3,
  parameter logic [7:0] FRAME_STOP  = 8'h3C,
  localparam int DEPTH  = FRAMES * PAYLOAD_BYTES,
  localparam int ADDR_W = $clog2(DEPTH + 1),
  localparam int CNT_MAX = (HDR_BYTES > PAYLOAD_BYTES) ? HDR_BYTES : PAYLOAD_BYTES,
  localparam int CNT_W  = $clog2(CNT_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        dataIn,
  input  ldStrobe_t         strobe,
  input  logic              doneWire,
  output logic              isPre,
  output logic              isStart,
  output logic              isStop,
  output logic              hdrLast,
  output logic              payLast,
  output logic              storeFull,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memData,
  output logic              devActive
);

  localparam int HDR_REST = (HDR_BYTES > 1) ? HDR_BYTES - 2 : 0;

  logic [CNT_W-1:0]  byteCnt;
  logic [ADDR_W-1:0] addrCnt;
  logic              activeQ;

  // byte counter inside the current header or payload phase
  always_ff @(posedge clk) begin
    if (rst) begin
      byteCnt <= '0;
    end else if (strobe.cntClr) begin
      byteCnt <= '0;
    end else if (strobe.cntInc) begin
      byteCnt <= byteCnt + 1'b1;
    end
  end

  // store fill pointer
  always_ff @(posedge clk) begin
    if (rst) begin
      addrCnt <= '0;
    end else if (strobe.memWr) begin
      addrCnt <= addrCnt + 1'b1;
    end
  end

  // registered write port toward the store
  always_ff @(posedge clk) begin
    if (rst) begin
      memWe   <= 1'b0;
      memAddr <= '0;
      memData <= '0;
    end else begin
      memWe <= strobe.memWr;
      if (strobe.memWr) begin
        memAddr <= addrCnt;
        memData <= dataIn;
      end
    end
  end

  // synchronise release of the shared done line
  always_ff @(posedge clk) begin
    if (rst) begin
      activeQ <= 1'b0;
    end else begin
      activeQ <= doneWire;
    end
  end

  assign isPre     = (dataIn == PREAMBLE);
  assign isStart   = (dataIn == FRAME_START);
  assign isStop    = (dataIn == FRAME_STOP);
  assign hdrLast   = (byteCnt == CNT_W'(HDR_REST));
  assign payLast   = (byteCnt == CNT_W'(PAYLOAD_BYTES - 1));
  assign storeFull = (addrCnt == ADDR_W'(DEPTH));
  assign devActive = activeQ;

endmodule

// File: rtl/cfg_loader_ctrl.sv
module cfg_loader_ctrl
  import cfg_loader_pkg::*;
#(
  parameter int HDR_BYTES = 3
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      csIn,
  input  logic      isPre,
  input  logic      isStart,
  input  logic      isStop,
  input  logic      hdrLast,
  input  logic      payLast,
  input  logic      storeFull,
  output ldStrobe_t strobe,
  output logic      statusOut,
  output logic      doneLow,
  output logic      errFlag
);

  ldState_e state, stateNext;
  logic     errQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_WAKE;
    end else begin
      state <= stateNext;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      errQ <= 1'b0;
    end else if (strobe.errSet) begin
      errQ <= 1'b1;
    end
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      S_WAKE: begin
        stateNext = S_HUNT;
      end
      S_HUNT: begin
        if (csIn && isPre) begin
          strobe.cntClr = 1'b1;
          stateNext     = (HDR_BYTES > 1) ? S_HDR : S_FSTART;
        end
      end
      S_HDR: begin
        if (csIn) begin
          if (hdrLast) begin
            strobe.cntClr = 1'b1;
            stateNext     = S_FSTART;
          end else begin
            strobe.cntInc = 1'b1;
          end
        end
      end
      S_FSTART: begin
        if (csIn) begin
          if (isStart) begin
            strobe.cntClr = 1'b1;
            stateNext     = S_PAY;
          end else begin
            strobe.errSet = 1'b1;
            stateNext     = S_FAULT;
          end
        end
      end
      S_PAY: begin
        if (csIn) begin
          strobe.memWr  = 1'b1;
          strobe.cntInc = 1'b1;
          if (payLast) begin
            stateNext = S_FSTOP;
          end
        end
      end
      S_FSTOP: begin
        if (csIn) begin
          if (!isStop) begin
            strobe.errSet = 1'b1;
            stateNext     = S_FAULT;
          end else if (storeFull) begin
            stateNext = S_FULL;
          end else begin
            stateNext = S_FSTART;
          end
        end
      end
      S_FULL:  stateNext = S_FULL;
      S_FAULT: stateNext = S_FAULT;
      default: stateNext = S_WAKE;
    endcase
  end

  assign statusOut = (state == S_FULL);
  assign doneLow   = (state != S_FULL);
  assign errFlag   = errQ;

endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
  import cfg_loader_pkg::*;
#(
  parameter int HDR_BYTES     = 3,
  parameter int PAYLOAD_BYTES = 4,
  parameter int FRAMES        = 4,
  parameter logic [7:0] PREAMBLE    = 8'hA5,
  parameter logic [7:0] FRAME_START = 8'hC3,
  parameter logic [7:0] FRAME_STOP  = 8'h3C,
  localparam int DEPTH  = FRAMES * PAYLOAD_BYTES,
  localparam int ADDR_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        dataIn,
  input  logic              csIn,
  output logic              statusOut,
  output logic              doneLow,
  input  logic              doneWire,
  output logic              devActive,
  output logic              errFlag,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memData
);

  ldStrobe_t strobe;
  logic isPre, isStart, isStop, hdrLast, payLast, storeFull;

  cfg_loader_ctrl #(
    .HDR_BYTES(HDR_BYTES)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .csIn     (csIn),
    .isPre    (isPre),
    .isStart  (isStart),
    .isStop   (isStop),
    .hdrLast  (hdrLast),
    .payLast  (payLast),
    .storeFull(storeFull),
    .strobe   (strobe),
    .statusOut(statusOut),
    .doneLow  (doneLow),
    .errFlag  (errFlag)
  );

  cfg_loader_dp #(
    .HDR_BYTES    (HDR_BYTES),
    .PAYLOAD_BYTES(PAYLOAD_BYTES),
    .FRAMES       (FRAMES),
    .PREAMBLE     (PREAMBLE),
    .FRAME_START  (FRAME_START),
    .FRAME_STOP   (FRAME_STOP)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .dataIn   (dataIn),
    .strobe   (strobe),
    .doneWire (doneWire),
    .isPre    (isPre),
    .isStart  (isStart),
    .isStop   (isStop),
    .hdrLast  (hdrLast),
    .payLast  (payLast),
    .storeFull(storeFull),
    .memWe    (memWe),
    .memAddr  (memAddr),
    .memData  (memData),
    .devActive(devActive)
  );

endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk #(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              csIn,
  input logic              statusOut,
  input logic              doneLow,
  input logic              errFlag,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr
);

  // R5
  write_needs_cs_chk: assert property (@(posedge clk) disable iff (rst)
    memWe |-> $past(csIn));

  // R4
  addr_range_chk: assert property (@(posedge clk) disable iff (rst)
    memWe |-> (memAddr < ADDR_W'(DEPTH)));

  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (memWe && $past(memWe)) |-> (memAddr == $past(memAddr) + 1'b1));

  // R6
  status_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $past(statusOut) |-> statusOut);

  // R6
  status_rise_cs_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(statusOut) |-> $past(csIn));

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    $past(errFlag) |-> errFlag);

  // R7
  err_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    errFlag |-> (!memWe && !statusOut));

  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(doneLow) |-> !doneLow);

endmodule

bind cfg_loader cfg_loader_chk #(
  .DEPTH (DEPTH),
  .ADDR_W(ADDR_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .csIn     (csIn),
  .statusOut(statusOut),
  .doneLow  (doneLow),
  .errFlag  (errFlag),
  .memWe    (memWe),
  .memAddr  (memAddr)
);

// File: tb/tb_cfg_loader.sv
`timescale 1ns/1ps
module tb_cfg_loader;

  localparam int HDR = 3;
  localparam int PAY = 3;
  localparam int FRM = 2;
  localparam int DEPTH = FRM * PAY;
  localparam int AW = $clog2(DEPTH + 1);
  localparam logic [7:0] PRE   = 8'h5A;
  localparam logic [7:0] START = 8'hC3;
  localparam logic [7:0] STOP  = 8'h5A; // equal to PRE on purpose (R9)

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] dataIn = 8'h00;
  logic leadCs = 1'b1;
  logic clrStats = 1'b1;

  logic statusA, doneLowA, activeA, errA, weA;
  logic statusB, doneLowB, activeB, errB, weB;
  logic [AW-1:0] addrA, addrB;
  logic [7:0] dataA, dataB;
  logic doneWire;

  assign doneWire = !(doneLowA || doneLowB);

  always #10 clk = ~clk;

  cfg_loader #(.HDR_BYTES(HDR), .PAYLOAD_BYTES(PAY), .FRAMES(FRM),
               .PREAMBLE(PRE), .FRAME_START(START), .FRAME_STOP(STOP)) dut (
    .clk(clk), .rst(rst), .dataIn(dataIn), .csIn(leadCs),
    .statusOut(statusA), .doneLow(doneLowA), .doneWire(doneWire),
    .devActive(activeA), .errFlag(errA),
    .memWe(weA), .memAddr(addrA), .memData(dataA));

  cfg_loader #(.HDR_BYTES(HDR), .PAYLOAD_BYTES(PAY), .FRAMES(FRM),
               .PREAMBLE(PRE), .FRAME_START(START), .FRAME_STOP(STOP)) dut2 (
    .clk(clk), .rst(rst), .dataIn(dataIn), .csIn(statusA),
    .statusOut(statusB), .doneLow(doneLowB), .doneWire(doneWire),
    .devActive(activeB), .errFlag(errB),
    .memWe(weB), .memAddr(addrB), .memData(dataB));

  // store models
  logic [7:0] memA [DEPTH];
  logic [7:0] memB [DEPTH];
  int wrA, wrB;

  always @(posedge clk) begin
    if (clrStats) begin
      wrA <= 0;
      wrB <= 0;
    end else begin
      if (weA) begin
        if (int'(addrA) < DEPTH) memA[addrA] <= dataA;
        wrA <= wrA + 1;
      end
      if (weB) begin
        if (int'(addrB) < DEPTH) memB[addrB] <= dataB;
        wrB <= wrB + 1;
      end
    end
  end

  int nChecks = 0;
  int nFails = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] payVal(input int dev, input int seed, input int idx);
    return 8'((seed * 37 + dev * 101 + idx * 13 + 5) & 255);
  endfunction

  task automatic sendByte(input logic [7:0] b, input bit cs = 1'b1);
    @(negedge clk);
    dataIn = b;
    leadCs = cs;
  endtask

  task automatic settle();
    @(posedge clk);
    #1;
  endtask

  // leaves the bus driving PRE for the wake-up edge
  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    clrStats = 1'b1;
    leadCs = 1'b1;
    dataIn = 8'h00;
    repeat (3) @(negedge clk);
    // R1: state while reset is held
    check(statusA == 1'b0 && statusB == 1'b0, "R1 status", statusA, 0);
    check(doneLowA == 1'b1 && doneLowB == 1'b1, "R1 doneLow", doneLowA, 1);
    check(errA == 1'b0 && weA == 1'b0 && activeA == 1'b0, "R1 err/we/active", errA, 0);
    rst = 1'b0;
    clrStats = 1'b0;
    dataIn = PRE;
  endtask

  task automatic sendHeader();
    sendByte(PRE);
    for (int k = 1; k < HDR; k++) sendByte(8'((k * 17) & 255));
  endtask

  task automatic loadDevice(input int dev, input int seed, input int dropAt);
    sendHeader();
    for (int f = 0; f < FRM; f++) begin
      sendByte(START);
      for (int p = 0; p < PAY; p++) begin
        if (f * PAY + p == dropAt) sendByte(8'hEE, 1'b0); // R5: ignored byte
        sendByte(payVal(dev, seed, f * PAY + p));
      end
      sendByte(STOP);
    end
  endtask

  initial begin
    #4000000;
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    for (int seed = 0; seed < 3; seed++) begin
      doReset();
      // R2: PRE on the wake-up edge must be ignored; R3: junk while hunting
      sendByte(8'h00);
      sendByte(START);
      loadDevice(0, seed, seed + 1);
      settle();
      // R6/R8: lead full, tail still loading
      check(statusA == 1'b1, "R6 lead status after fill", statusA, 1);
      check(doneLowA == 1'b0, "R8 lead releases done", doneLowA, 0);
      check(activeA == 1'b0 && activeB == 1'b0, "R8 inactive while tail pulls low", activeA, 0);
      check(statusB == 1'b0 && wrB == 0, "R5 tail ignores bus while cs low", wrB, 0);
      check(errA == 1'b0, "R2 R3 lead loads without error", errA, 0);
      // R9: tail takes the very next byte as its preamble
      loadDevice(1, seed, -1);
      settle();
      check(statusB == 1'b1, "R9 tail full", statusB, 1);
      check(errB == 1'b0, "R9 tail no error", errB, 0);
      check(activeA == 1'b0 && activeB == 1'b0, "R8 active not yet", activeB, 0);
      sendByte(8'h00);
      settle();
      check(activeA == 1'b1 && activeB == 1'b1, "R8 active together", activeA, 1);
      // R6: bytes after full have no effect
      sendByte(START);
      for (int k = 0; k < 3; k++) sendByte(8'h12);
      sendByte(PRE);
      repeat (3) sendByte(8'h00);
      check(wrA == DEPTH, "R6 lead write count", wrA, DEPTH);
      check(wrB == DEPTH, "R6 tail write count", wrB, DEPTH);
      check(statusA == 1'b1 && statusB == 1'b1, "R6 status stays high", statusB, 1);
      for (int i = 0; i < DEPTH; i++) begin
        check(memA[i] == payVal(0, seed, i), "R4 R5 lead store", memA[i], payVal(0, seed, i));
        check(memB[i] == payVal(1, seed, i), "R4 R9 tail store", memB[i], payVal(1, seed, i));
      end
    end

    // R7: bad start marker
    doReset();
    sendHeader();
    sendByte(8'h00);
    settle();
    check(errA == 1'b1, "R7 bad start raises error", errA, 1);
    sendByte(START);
    for (int k = 0; k < PAY; k++) sendByte(8'h33);
    sendByte(STOP);
    repeat (3) sendByte(8'h00);
    check(errA == 1'b1, "R7 error sticky", errA, 1);
    check(wrA == 0, "R7 no writes after bad start", wrA, 0);
    check(statusA == 1'b0 && doneLowA == 1'b1, "R7 status/done held", statusA, 0);

    // R7: bad stop marker after one good payload
    doReset();
    sendHeader();
    sendByte(START);
    for (int k = 0; k < PAY; k++) sendByte(8'(k + 1));
    sendByte(8'h00);
    settle();
    check(errA == 1'b1, "R7 bad stop raises error", errA, 1);
    sendByte(START);
    for (int k = 0; k < PAY; k++) sendByte(8'h44);
    repeat (3) sendByte(8'h00);
    check(wrA == PAY, "R7 only pre-error payload written", wrA, PAY);
    check(statusA == 1'b0 && doneLowA == 1'b1, "R7 status/done held after stop error", statusA, 0);
    for (int k = 0; k < PAY; k++)
      check(memA[k] == 8'(k + 1), "R4 payload before bad stop", memA[k], k + 1);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule